// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block stands in for one Ethernet PHY's management registers, seen from the MAC through a single 32-bit frame word. Software (or a MAC-side controller) writes a frame word that names an operation (read or write), a 10-bit address and 16 bits of write data. The block performs the access against its internal PHY registers and, for a read, places the 16-bit result in the low half of the frame word. It then raises a management-done flag.

Each access takes three states of a small controller. `ST_IDLE` waits for a frame word, and the transition IDLE to ACCESS is taken when `frame_wr` is high. `ST_ACCESS` performs the register read or write, and always moves on to DONE. `ST_DONE` sets the done flag and always returns to IDLE. The PHY side also watches a `link_up` input. On each link edge it updates the link and negotiation-complete bits of the status register, and it latches cause bits in an interrupt-source register. Reading that register clears it.

The address field is split into a 5-bit PHY number in the upper half and a 5-bit register index in the lower half. Only PHY number 0 answers. Auto-negotiation completes at once when software enables it.

Top module: `mii_phy_model`

## Requirements
- R1: After reset, control reads 0x3000, status reads 0x7809, advertisement reads 0x01E1, interrupt source and interrupt mask read 0x0000, `frame_q` is 0 and `mgmt_done` is 0.
- R2: A frame word written while `mgmt_busy` is low is stored whole in `frame_q`. `mgmt_busy` then stays high for exactly two cycles (ACCESS, DONE). A `frame_wr` pulse while busy is ignored and performs no access.
- R3: Bit 29 of the frame word set means read. The PHY number is bits 27:23 and the register index is bits 22:18. A read replaces `frame_q[15:0]` with the register value and leaves `frame_q[31:16]` unchanged. A write uses bits 15:0 as data.
- R4: A write to control (index 0) stores data & 0x7980. If data bit 12 is set, status bit 5 (0x0020) becomes set and stays set.
- R5: A write to advertisement (index 4) stores (data & 0x2D7F) | 0x0080. A write to interrupt mask (index 30) stores data & 0x00FF.
- R6: Indices 5 and 6, and every index other than 0, 1, 4, 29 and 30, read as 0x0000. Writes to them, to status (index 1) and to interrupt source (index 29) change nothing.
- R7: A non-zero PHY number reads as 0xFFFF, and writes with a non-zero PHY number change no register.
- R8: A rising `link_up` sets status bits 0x0024 and interrupt-source bits 7 and 6. A falling `link_up` clears status bits 0x0024 and sets interrupt-source bit 4.
- R9: A read of interrupt source returns its value and clears it. A link event in the same cycle as that clear still leaves its bits set.
- R10: `mgmt_done` rises on the cycle `mgmt_busy` falls, after every read or write. It holds until `done_clr` is high in a cycle with no completion. A completion wins over a simultaneous `done_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_wr | input | 1 | Load a new frame word and start an access |
| frame_wdata | input | 32 | Frame word: operation, address, write data |
| done_clr | input | 1 | Clear the management-done flag |
| link_up | input | 1 | Link state from the line side |
| frame_q | output | 32 | Current frame word, with read data in the low half |
| mgmt_done | output | 1 | Management-done event flag |
| mgmt_busy | output | 1 | An access is in progress |

## Verification
The assertions assume that `link_up` is a synchronous level that holds for at least one cycle. They assume nothing about when `frame_wr` is asserted: the busy-window and hold checks are written so that a stray issue during an access must be dropped. The stimulus normally waits for `mgmt_busy` to fall before the next frame word. It breaks this rule only once, on purpose, to show that an issue during busy is ignored. It moves `link_up` and `done_clr` both at idle and inside the ACCESS and DONE cycles, so that the same-cycle priority rules are exercised.

// File: rtl/mii_phy_pkg.sv
package mii_phy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_DONE   = 2'd2
    } mgmt_state_t;

    localparam int REG_W = 16;
    localparam int IDX_W = 5;

    localparam logic [IDX_W-1:0] IDX_CTRL = 5'd0;
    localparam logic [IDX_W-1:0] IDX_STAT = 5'd1;
    localparam logic [IDX_W-1:0] IDX_ADV  = 5'd4;
    localparam logic [IDX_W-1:0] IDX_ISRC = 5'd29;
    localparam logic [IDX_W-1:0] IDX_IMSK = 5'd30;

    localparam logic [REG_W-1:0] CTRL_RST  = 16'h3000;
    localparam logic [REG_W-1:0] STAT_RST  = 16'h7809;
    localparam logic [REG_W-1:0] ADV_RST   = 16'h01E1;

    localparam logic [REG_W-1:0] CTRL_MASK = 16'h7980;
    localparam logic [REG_W-1:0] ADV_MASK  = 16'h2D7F;
    localparam logic [REG_W-1:0] ADV_FORCE = 16'h0080;
    localparam logic [REG_W-1:0] IMSK_MASK = 16'h00FF;

    localparam int               CTRL_ANEN_BIT = 12;
    localparam logic [REG_W-1:0] STAT_ANDONE   = 16'h0020;
    localparam logic [REG_W-1:0] STAT_LINKBITS = 16'h0024;
    localparam logic [REG_W-1:0] ISRC_UP       = 16'h00C0;
    localparam logic [REG_W-1:0] ISRC_DOWN     = 16'h0010;

endpackage

// File: rtl/link_monitor.sv
module link_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    output logic up_evt,
    output logic down_evt
);
    logic link_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) link_prev_q <= 1'b0;
        else        link_prev_q <= link_up;
    end

    assign up_evt   =  link_up && !link_prev_q;
    assign down_evt = !link_up &&  link_prev_q;
endmodule

// File: rtl/phy_reg_file.sv
module phy_reg_file
    import mii_phy_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_read,
    input  logic             acc_phy_ok,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [REG_W-1:0] acc_wdata,
    input  logic             up_evt,
    input  logic             down_evt,
    output logic [REG_W-1:0] rd_data
);
    logic [REG_W-1:0] ctrl_q, stat_q, adv_q, isrc_q, imsk_q;
    logic [REG_W-1:0] ctrl_n, stat_n, adv_n, isrc_n, imsk_n;
    logic             wr_hit, rd_hit;

    assign wr_hit = acc_en && !acc_read && acc_phy_ok;
    assign rd_hit = acc_en &&  acc_read && acc_phy_ok;

    always_comb begin
        rd_data = '0;
        if (!acc_phy_ok) begin
            rd_data = '1;
        end else begin
            case (acc_idx)
                IDX_CTRL: rd_data = ctrl_q;
                IDX_STAT: rd_data = stat_q;
                IDX_ADV:  rd_data = adv_q;
                IDX_ISRC: rd_data = isrc_q;
                IDX_IMSK: rd_data = imsk_q;
                default:  rd_data = '0;
            endcase
        end
    end

    always_comb begin
        ctrl_n = ctrl_q;
        stat_n = stat_q;
        adv_n  = adv_q;
        isrc_n = isrc_q;
        imsk_n = imsk_q;
        if (wr_hit) begin
            case (acc_idx)
                IDX_CTRL: begin
                    ctrl_n = acc_wdata & CTRL_MASK;
                    if (acc_wdata[CTRL_ANEN_BIT]) stat_n = stat_n | STAT_ANDONE;
                end
                IDX_ADV:  adv_n  = (acc_wdata & ADV_MASK) | ADV_FORCE;
                IDX_IMSK: imsk_n = acc_wdata & IMSK_MASK;
                default:  ;
            endcase
        end
        if (rd_hit && acc_idx == IDX_ISRC) isrc_n = '0;
        if (up_evt) begin
            stat_n = stat_n | STAT_LINKBITS;
            isrc_n = isrc_n | ISRC_UP;
        end
        if (down_evt) begin
            stat_n = stat_n & ~STAT_LINKBITS;
            isrc_n = isrc_n | ISRC_DOWN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            stat_q <= STAT_RST;
            adv_q  <= ADV_RST;
            isrc_q <= '0;
            imsk_q <= '0;
        end else begin
            ctrl_q <= ctrl_n;
            stat_q <= stat_n;
            adv_q  <= adv_n;
            isrc_q <= isrc_n;
            imsk_q <= imsk_n;
        end
    end
endmodule

// File: rtl/mii_frame_fsm.sv
module mii_frame_fsm
    import mii_phy_pkg::*;
#(
    parameter int FRAME_W  = 32,
    parameter int RD_BIT   = 29,
    parameter int ADDR_LSB = 18,
    parameter int ADDR_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic               done_clr,
    input  logic [REG_W-1:0]   rd_data,
    output logic               acc_en,
    output logic               acc_read,
    output logic               acc_phy_ok,
    output logic [IDX_W-1:0]   acc_idx,
    output logic [REG_W-1:0]   acc_wdata,
    output logic [FRAME_W-1:0] frame_q,
    output logic               mgmt_done,
    output logic               busy
);
    localparam int PHY_W   = ADDR_W - IDX_W;
    localparam int PHY_LSB = ADDR_LSB + IDX_W;

    mgmt_state_t state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (frame_wr) state_n = ST_ACCESS;
            ST_ACCESS: state_n = ST_DONE;
            ST_DONE:   state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    assign busy       = (state_q != ST_IDLE);
    assign acc_en     = (state_q == ST_ACCESS);
    assign acc_read   = frame_q[RD_BIT];
    assign acc_idx    = frame_q[ADDR_LSB +: IDX_W];
    assign acc_phy_ok = (frame_q[PHY_LSB +: PHY_W] == '0);
    assign acc_wdata  = frame_q[REG_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q   <= '0;
            mgmt_done <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (frame_wr) frame_q <= frame_wdata;
                    if (done_clr) mgmt_done <= 1'b0;
                end
                ST_ACCESS: begin
                    if (acc_read) frame_q[REG_W-1:0] <= rd_data;
                    if (done_clr) mgmt_done <= 1'b0;
                end
                ST_DONE: mgmt_done <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mii_phy_model.sv
module mii_phy_model
    import mii_phy_pkg::*;
#(
    parameter int FRAME_W  = 32,
    parameter int RD_BIT   = 29,
    parameter int ADDR_LSB = 18,
    parameter int ADDR_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic               done_clr,
    input  logic               link_up,
    output logic [FRAME_W-1:0] frame_q,
    output logic               mgmt_done,
    output logic               mgmt_busy
);
    logic             acc_en, acc_read, acc_phy_ok;
    logic [IDX_W-1:0] acc_idx;
    logic [REG_W-1:0] acc_wdata, rd_data;
    logic             up_evt, down_evt;

    mii_frame_fsm #(
        .FRAME_W (FRAME_W),
        .RD_BIT  (RD_BIT),
        .ADDR_LSB(ADDR_LSB),
        .ADDR_W  (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_wr   (frame_wr),
        .frame_wdata(frame_wdata),
        .done_clr   (done_clr),
        .rd_data    (rd_data),
        .acc_en     (acc_en),
        .acc_read   (acc_read),
        .acc_phy_ok (acc_phy_ok),
        .acc_idx    (acc_idx),
        .acc_wdata  (acc_wdata),
        .frame_q    (frame_q),
        .mgmt_done  (mgmt_done),
        .busy       (mgmt_busy)
    );

    phy_reg_file u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_read  (acc_read),
        .acc_phy_ok(acc_phy_ok),
        .acc_idx   (acc_idx),
        .acc_wdata (acc_wdata),
        .up_evt    (up_evt),
        .down_evt  (down_evt),
        .rd_data   (rd_data)
    );

    link_monitor u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .up_evt  (up_evt),
        .down_evt(down_evt)
    );
endmodule

// File: rtl/mii_phy_model_chk.sv
module mii_phy_model_chk #(
    parameter int FRAME_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_wr,
    input logic               done_clr,
    input logic               mgmt_busy,
    input logic               mgmt_done,
    input logic [FRAME_W-1:0] frame_q
);
    // R2
    issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && !mgmt_busy) |=> mgmt_busy);

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mgmt_busy) |=> mgmt_busy);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_busy && !frame_wr) |=> $stable(frame_q));

    // R3
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_busy |=> (frame_q[FRAME_W-1:16] == $past(frame_q[FRAME_W-1:16])));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_done && !done_clr) |=> mgmt_done);

    // R10
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mgmt_busy) |-> mgmt_done);

    // R10
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mgmt_done) |-> $fell(mgmt_busy));
endmodule

bind mii_phy_model mii_phy_model_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_wr (frame_wr),
    .done_clr (done_clr),
    .mgmt_busy(mgmt_busy),
    .mgmt_done(mgmt_done),
    .frame_q  (frame_q)
);

// File: tb/mii_phy_model_tb.sv
`timescale 1ns/1ps
module mii_phy_model_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_wr = 1'b0;
    logic [31:0] frame_wdata = '0;
    logic        done_clr = 1'b0;
    logic        link_up = 1'b0;
    logic [31:0] frame_q;
    logic        mgmt_done;
    logic        mgmt_busy;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_word_q[$];
    string       exp_tag_q[$];

    always #2 clk = ~clk;

    mii_phy_model u_dut (
        .clk(clk), .rst_n(rst_n), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
        .done_clr(done_clr), .link_up(link_up), .frame_q(frame_q),
        .mgmt_done(mgmt_done), .mgmt_busy(mgmt_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic rd, input logic [4:0] phy,
                                       input logic [4:0] idx, input logic [15:0] d);
        logic [31:0] w;
        w = 32'h4002_0000;
        w[29] = rd;
        w[27:23] = phy;
        w[22:18] = idx;
        w[15:0] = rd ? 16'hA5A5 : d;
        return w;
    endfunction

    // Monitor: on each completion compare the frame word and done flag.
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (rst_n && prev_busy && !mgmt_busy) begin
            if (exp_word_q.size() == 0) begin
                chk("R2 unexpected completion", 32'h1, 32'h0);
            end else begin
                chk(exp_tag_q.pop_front(), frame_q, exp_word_q.pop_front());
            end
            chk("R10 done at completion", {31'h0, mgmt_done}, 32'h1);
        end
        prev_busy = mgmt_busy;
    end

    task automatic push(input logic [31:0] w, input logic [15:0] exp, input string tag);
        exp_word_q.push_back(w[29] ? {w[31:16], exp} : w);
        exp_tag_q.push_back(tag);
    endtask

    task automatic op(input logic rd, input logic [4:0] phy, input logic [4:0] idx,
                      input logic [15:0] d, input logic [15:0] exp, input string tag);
        logic [31:0] w;
        w = mk(rd, phy, idx, d);
        push(w, exp, tag);
        @(negedge clk);
        frame_wr = 1'b1;
        frame_wdata = w;
        @(negedge clk);
        frame_wr = 1'b0;
        while (mgmt_busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 frame_q reset", frame_q, 32'h0);
        chk("R1 done reset", {31'h0, mgmt_done}, 32'h0);
        op(1, 0, 0,  0, 16'h3000, "R1 control reset");
        op(1, 0, 1,  0, 16'h7809, "R1 status reset");
        op(1, 0, 4,  0, 16'h01E1, "R1 adv reset");
        op(1, 0, 29, 0, 16'h0000, "R1 isrc reset");
        op(1, 0, 30, 0, 16'h0000, "R1 imask reset");

        // R4
        op(0, 0, 0, 16'hFFFF, 0, "R4 write ctrl");
        op(1, 0, 0, 0, 16'h7980, "R4 ctrl masked");
        op(1, 0, 1, 0, 16'h7829, "R4 an complete");
        op(0, 0, 0, 16'h0000, 0, "R4 write ctrl zero");
        op(1, 0, 0, 0, 16'h0000, "R4 ctrl zero");
        op(1, 0, 1, 0, 16'h7829, "R4 an bit sticky");

        // R5
        op(0, 0, 4, 16'hFFFF, 0, "R5 write adv");
        op(1, 0, 4, 0, 16'h2DFF, "R5 adv ones");
        op(0, 0, 4, 16'h0000, 0, "R5 write adv zero");
        op(1, 0, 4, 0, 16'h0080, "R5 adv forced bit");
        op(0, 0, 30, 16'hABCD, 0, "R5 write mask");
        op(1, 0, 30, 0, 16'h00CD, "R5 mask low byte");

        // R6
        op(1, 0, 5, 0, 16'h0000, "R6 reg5 zero");
        op(1, 0, 6, 0, 16'h0000, "R6 reg6 zero");
        op(0, 0, 7, 16'h1234, 0, "R6 write reg7");
        op(1, 0, 7, 0, 16'h0000, "R6 reg7 zero");
        op(0, 0, 1, 16'h0000, 0, "R6 write status");
        op(1, 0, 1, 0, 16'h7829, "R6 status unchanged");

        // R7
        op(1, 3, 0, 0, 16'hFFFF, "R7 other phy read");
        op(0, 1, 0, 16'h1000, 0, "R7 other phy write");
        op(1, 0, 0, 0, 16'h0000, "R7 ctrl untouched");

        // R8
        link_up = 1'b1;
        repeat (2) @(negedge clk);
        op(1, 0, 1, 0, 16'h782D, "R8 link up status");
        op(1, 0, 29, 0, 16'h00C0, "R8 link up isrc");
        op(1, 0, 29, 0, 16'h0000, "R9 isrc cleared");
        link_up = 1'b0;
        repeat (2) @(negedge clk);
        op(1, 0, 1, 0, 16'h7809, "R8 link down status");
        op(1, 0, 29, 0, 16'h0010, "R8 link down isrc");

        // R9: link event in the same cycle as the clearing read
        w = mk(1, 0, 29, 0);
        push(w, 16'h0000, "R9 read during event");
        @(negedge clk);
        frame_wr = 1'b1;
        frame_wdata = w;
        @(negedge clk);
        frame_wr = 1'b0;
        link_up = 1'b1;
        while (mgmt_busy) @(negedge clk);
        op(1, 0, 29, 0, 16'h00C0, "R9 event survives clear");

        // R2: issue during busy ignored
        w = mk(1, 0, 0, 0);
        push(w, 16'h0000, "R2 read with stray issue");
        @(negedge clk);
        frame_wr = 1'b1;
        frame_wdata = w;
        @(negedge clk);
        frame_wdata = 32'h5000_FFFF;
        @(negedge clk);
        frame_wr = 1'b0;
        while (mgmt_busy) @(negedge clk);
        @(negedge clk);
        chk("R2 no second access", {31'h0, mgmt_busy}, 32'h0);
        op(1, 0, 0, 0, 16'h0000, "R2 ctrl not written");

        // R10: clear together with completion, then alone
        w = mk(1, 0, 4, 0);
        push(w, 16'h0080, "R10 read with clear");
        @(negedge clk);
        frame_wr = 1'b1;
        frame_wdata = w;
        @(negedge clk);
        frame_wr = 1'b0;
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        @(negedge clk);
        chk("R10 done held", {31'h0, mgmt_done}, 32'h1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk("R10 done cleared", {31'h0, mgmt_done}, 32'h0);
        @(negedge clk);
        chk("R10 done stays clear", {31'h0, mgmt_done}, 32'h0);

        repeat (2) @(negedge clk);
        chk("R2 scoreboard drained", exp_word_q.size(), 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule